// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block is a small register of four flip-flops that can take a parallel word, move its contents one place in either direction with a new bit entering from the vacated end, or keep its contents unchanged. A two-bit select chooses the operation. The register acts on each rising clock edge. An active-low clear empties the register at once, with no wait for a clock edge.

The outputs form a packed vector `q`. Bit `q[3]` is the first stage and `q[0]` is the last. A right shift moves data from the MSB toward the LSB. A left shift moves it from the LSB toward the MSB. The parallel word `par_d` uses the same bit order.

The select is decoded into one of four operating modes:
- `OP_HOLD`
- `OP_RIGHT`
- `OP_LEFT`
- `OP_LOAD`

The mode is re-evaluated on every edge, so any mode can follow any other mode with no extra cycle between them. An edge in a given mode updates the register as that mode defines. An active clear sends the register to all zeros from any mode.

Top module: `univ_shift_reg`

## Requirements
- R1: While `clr_n` is 0, `q` is 4'b0000. The clear takes effect at once, even in the middle of a clock cycle, and it overrides the clock, the select and the data inputs.
- R2: With {sel1,sel0} = 2'b11 (load), a rising edge copies `par_d` into `q`, so `par_d[3]` goes to `q[3]`. Both serial inputs have no effect during a load.
- R3: With {sel1,sel0} = 2'b01 (right shift), a rising edge makes `q` equal to {ser_right, old q[3:1]}.
- R4: With {sel1,sel0} = 2'b10 (left shift), a rising edge makes `q` equal to {old q[2:0], ser_left}.
- R5: With {sel1,sel0} = 2'b00 (hold), a rising edge leaves `q` unchanged, whatever `par_d` and the serial inputs are doing.
- R6: While `clr_n` is 1, `q` changes only at a rising clock edge. Changes to the select or data inputs between edges have no effect on `q`.
- R7: Releasing the clear does not change `q`. The first rising edge after release applies the mode decoded at that edge.
- R8: During a shift, the serial input for the other direction has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel1 | input | 1 | Upper bit of the mode select |
| sel0 | input | 1 | Lower bit of the mode select |
| ser_right | input | 1 | Bit that enters `q[3]` on a right shift |
| ser_left | input | 1 | Bit that enters `q[0]` on a left shift |
| par_d | input | 4 | Parallel word, taken in a load |
| q | output | 4 | Register contents; `q[3]` is the first stage |

## Verification
Loads are applied with several words, including 0000, 1111 and alternating patterns, while the serial inputs toggle. These tests show whether every bit reaches its own position and whether a serial bit leaks into a load. Right and left shifts are run with irregular serial sequences while the opposite serial input carries the complement. This tells the two directions apart and exposes a swapped entry point or a wrong end bit. Hold edges and input changes between edges are run with changing data, which exposes any write path that is not gated. The mid-cycle clear, its release, and a long run of random modes compared against a bench model check the override and the mode-to-mode transitions.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    // The mode code is {sel1, sel0}.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_LOAD  = 2'b11
    } shreg_op_e;
endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic      sel1,
    input  logic      sel0,
    output shreg_op_e op
);
    always_comb begin
        unique case ({sel1, sel0})
            2'b11:   op = OP_LOAD;
            2'b01:   op = OP_RIGHT;
            2'b10:   op = OP_LEFT;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/shreg_next.sv
module shreg_next
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  shreg_op_e        op,
    input  logic [WIDTH-1:0] q_cur,
    input  logic [WIDTH-1:0] par_d,
    input  logic             ser_right,
    input  logic             ser_left,
    output logic [WIDTH-1:0] q_nxt
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (op)
            OP_LOAD:  q_nxt = par_d;
            OP_RIGHT: q_nxt = {ser_right, q_cur[MSB:1]};
            OP_LEFT:  q_nxt = {q_cur[MSB-1:0], ser_left};
            OP_HOLD:  q_nxt = q_cur;
            default:  q_nxt = q_cur;
        endcase
    end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sel1,
    input  logic             sel0,
    input  logic             ser_right,
    input  logic             ser_left,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q
);
    shreg_op_e        op;
    logic [WIDTH-1:0] q_reg;
    logic [WIDTH-1:0] q_nxt;

    shreg_mode_dec u_dec (
        .sel1 (sel1),
        .sel0 (sel0),
        .op   (op)
    );

    shreg_next #(.WIDTH(WIDTH)) u_next (
        .op        (op),
        .q_cur     (q_reg),
        .par_d     (par_d),
        .ser_right (ser_right),
        .ser_left  (ser_left),
        .q_nxt     (q_nxt)
    );

    // State register; the clear is asynchronous.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_reg <= '0;
        else        q_reg <= q_nxt;
    end

    // Output process.
    always_comb q = q_reg;
endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             sel1,
    input logic             sel0,
    input logic             ser_right,
    input logic             ser_left,
    input logic [WIDTH-1:0] par_d,
    input logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (sel1 && sel0) |=> (q == $past(par_d)));

    assert_right_shift_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (!sel1 && sel0) |=> (q == {$past(ser_right), $past(q[MSB:1])}));

    assert_left_shift_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (sel1 && !sel0) |=> (q == {$past(q[MSB-1:0]), $past(ser_left)}));

    assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (!sel1 && !sel0) |=> $stable(q));
endmodule

bind univ_shift_reg shreg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .sel1      (sel1),
    .sel0      (sel0),
    .ser_right (ser_right),
    .ser_left  (ser_left),
    .par_d     (par_d),
    .q         (q)
);

// File: tb/tb_univ_shift_reg.sv
module tb_univ_shift_reg;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       sel1 = 1'b0;
    logic       sel0 = 1'b0;
    logic       ser_right = 1'b0;
    logic       ser_left = 1'b0;
    logic [3:0] par_d = 4'h0;
    logic [3:0] q;
    logic [3:0] exp_q;
    int         n_run = 0;
    int         n_fail = 0;

    univ_shift_reg dut (
        .clk(clk), .clr_n(clr_n), .sel1(sel1), .sel0(sel0),
        .ser_right(ser_right), .ser_left(ser_left), .par_d(par_d), .q(q)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Bench model of one edge.
    function automatic logic [3:0] model(input logic [3:0] cur, input logic s1, input logic s0,
                                         input logic sr, input logic sl, input logic [3:0] d);
        case ({s1, s0})
            2'b11:   return d;
            2'b01:   return {sr, cur[3:1]};
            2'b10:   return {cur[2:0], sl};
            default: return cur;
        endcase
    endfunction

    // Drive inputs 2 ns after an edge, then take one edge and check.
    task automatic step(input string req, input logic s1, input logic s0,
                        input logic sr, input logic sl, input logic [3:0] d);
        sel1 = s1; sel0 = s0; ser_right = sr; ser_left = sl; par_d = d;
        exp_q = model(exp_q, s1, s0, sr, sl, d);
        @(posedge clk); #2;
        check(req, q, exp_q);
    endtask

    task automatic t_reset;
        #2 check("R1 reset", q, 4'b0000);
        @(posedge clk); #2;
        check("R1 held under clear", q, 4'b0000);
        clr_n = 1'b1;
        exp_q = 4'b0000;
    endtask

    task automatic t_load;
        step("R2 load 1010", 1, 1, 1, 0, 4'b1010);
        step("R2 load 0101", 1, 1, 0, 1, 4'b0101);
        step("R2 load 1111", 1, 1, 0, 0, 4'b1111);
        step("R2 load 0000", 1, 1, 1, 1, 4'b0000);
        step("R2 load 1000", 1, 1, 1, 1, 4'b1000);
    endtask

    task automatic t_right;
        step("R2 preload", 1, 1, 0, 0, 4'b0000);
        step("R3 right 1", 0, 1, 1, 0, 4'b1111);
        step("R3 right 0", 0, 1, 0, 1, 4'b1111);
        step("R3 right 1 R8", 0, 1, 1, 0, 4'b0000);
        step("R3 right 1 R8", 0, 1, 1, 0, 4'b0101);
        step("R3 right 0 R8", 0, 1, 0, 1, 4'b0101);
        check("R3 pattern", q, 4'b0110);
    endtask

    task automatic t_left;
        step("R2 preload", 1, 1, 0, 0, 4'b1001);
        step("R4 left 1", 1, 0, 0, 1, 4'b0000);
        step("R4 left 0", 1, 0, 1, 0, 4'b1111);
        step("R4 left 0 R8", 1, 0, 1, 0, 4'b1111);
        step("R4 left 1 R8", 1, 0, 0, 1, 4'b0000);
        check("R4 pattern", q, 4'b1001);
    endtask

    task automatic t_hold;
        step("R2 preload", 1, 1, 0, 0, 4'b0110);
        step("R5 hold a", 0, 0, 1, 1, 4'b1001);
        step("R5 hold b", 0, 0, 0, 0, 4'b1111);
        step("R5 hold c", 0, 0, 1, 0, 4'b0000);
        check("R5 value kept", q, 4'b0110);
    endtask

    task automatic t_between;
        step("R2 preload", 1, 1, 0, 0, 4'b1100);
        sel1 = 1; sel0 = 1; par_d = 4'b0011; ser_right = 1; ser_left = 1;
        #1 check("R6 no edge load", q, 4'b1100);
        sel0 = 0;
        #1 check("R6 no edge left", q, 4'b1100);
        sel1 = 0; sel0 = 1;
        #1 check("R6 no edge right", q, 4'b1100);
        sel0 = 0;
    endtask

    task automatic t_mid_clear;
        step("R2 preload", 1, 1, 0, 0, 4'b1111);
        #1 clr_n = 1'b0;
        #1 check("R1 mid-cycle clear", q, 4'b0000);
        @(posedge clk); #2;
        check("R1 clear overrides load", q, 4'b0000);
        #1 clr_n = 1'b1;
        #1 check("R7 release no change", q, 4'b0000);
        exp_q = 4'b0000;
        step("R7 first edge right", 0, 1, 1, 0, 4'b1111);
        check("R7 first edge value", q, 4'b1000);
    endtask

    task automatic t_random;
        for (int i = 0; i < 60; i++) begin
            logic [3:0] rv;
            rv = 4'($urandom);
            step("R2 R3 R4 R5 random", rv[0], rv[1], rv[2], rv[3], 4'($urandom));
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: q=%b expected run end", q);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        exp_q = 4'b0000;
        t_reset();
        t_load();
        t_right();
        t_left();
        t_hold();
        t_between();
        t_mid_clear();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule